// File: doc/BRIEF.md
# Passive Load Host for SRAM-Configured Devices

This block sits on the host side of a board and loads a volatile, SRAM-configured target device over a passive link. A `start` pulse makes it pull the target's active-low request line low for a fixed number of clocks and then release it. It then waits for the target's status line to rise. After that it draws bytes from a ready/valid byte source and presents them on `dout`, one data-clock period per unit, while it generates the data clock `dclk` itself. In serial mode a unit is one bit on `dout[0]`, least-significant bit first. In parallel mode a unit is the whole byte on `dout`.

Once the byte marked `s_last` has gone out, the host keeps `dclk` running with `dout` parked at zero until the target releases its done line. If `use_init` was set at start, the host then keeps clocking until the init-done line rises. The result is reported on `ok` or `err`, with a cause in `err_code`. If the status line collapses while data is moving, the host drops the transfer and pulses the request line again, up to a bounded number of attempts. While the request line is low it raises `src_restart`, so that the source rewinds to its first byte.

The controller is one state machine with eight states: IDLE, PULSE, WAIT_STAT, LOAD, FLUSH, INIT, OK and FAIL. The transitions are named as follows:
- start: any state to PULSE.
- pulse_end: PULSE to WAIT_STAT.
- stat_up: WAIT_STAT to LOAD.
- stat_tmo: WAIT_STAT to FAIL.
- last_sent: LOAD to FLUSH.
- stat_lost: LOAD or FLUSH to PULSE while attempts remain, otherwise to FAIL.
- done_seen: FLUSH to INIT or OK.
- done_tmo: FLUSH to FAIL.
- init_seen: INIT to OK.
- init_tmo: INIT to FAIL.

Top module: `pcfg_host`

## Requirements
- R1: The edge after `start` is sampled high (in any state), `cfg_req_n` goes low. It stays low for exactly PULSE_MIN clocks, and `src_restart` is high for exactly those clocks.
- R2: No byte is accepted and no `dclk` rising edge occurs until `cfg_status` has been seen high after the pulse. If status stays low for WAIT_TMO clocks, the host stops with `err` high and `err_code` = 1.
- R3: `dout` never changes at the clock edge on which `dclk` rises. Each rising edge of `dclk` captures a value that was set up at least one system clock before it.
- R4: In serial mode (`par_mode` = 0 at start), each byte goes out as 8 rising edges on `dout[0]`, bit 0 first, and `dout[7:1]` stays 0. In parallel mode, each byte goes out whole on one rising edge.
- R5: After the `s_last` byte, `dclk` keeps toggling with `dout` = 0. Once `cfg_done` is seen high, loading ends. If done has not risen after EXTRA_CLKS extra rising edges, the host stops with `err_code` = 3.
- R6: With `use_init` = 1, `ok` rises only after `cfg_init_done` is seen high. If init-done does not rise within WAIT_TMO clocks after done, `err_code` = 4. With `use_init` = 0, init-done is ignored.
- R7: `cfg_status` going low during LOAD or FLUSH aborts the transfer and restarts from the request pulse. This happens at most RETRY_MAX times, so there are at most RETRY_MAX+1 pulses per start. A further loss ends with `err_code` = 2.
- R8: Whenever no data unit is being presented, `dout` is driven to 0, never left undefined. Whenever `busy` is low, `dclk` is low.
- R9: After reset, `cfg_req_n` = 1, `dclk` = 0, `dout` = 0, and `busy`, `ok`, `err`, `s_ready` and `err_code` are all 0. `ok` and `err` are never high together, and each holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a load |
| par_mode | input | 1 | 1 = byte per data clock, 0 = bit per data clock; sampled at start |
| use_init | input | 1 | Wait for init-done before success; sampled at start |
| s_data | input | DW | Source byte |
| s_valid | input | 1 | Source byte valid |
| s_last | input | 1 | Source byte is the final one |
| s_ready | output | 1 | Host takes the byte this cycle |
| src_restart | output | 1 | Source must return to its first byte |
| cfg_req_n | output | 1 | Active-low load request to the target |
| cfg_status | input | 1 | Target status line (high = ready, no fault) |
| cfg_done | input | 1 | Target load-complete line |
| cfg_init_done | input | 1 | Target initialization-complete line |
| dclk | output | 1 | Data clock to the target |
| dout | output | DW | Data to the target (serial uses bit 0) |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |
| err_code | output | 3 | 0 none, 1 status timeout, 2 status lost, 3 done timeout, 4 init timeout |

## Verification
The timing of each result is fixed:
- The request line falls one clock after `start`.
- A byte is taken on the clock edge where `s_ready` and `s_valid` are both high, and its first unit is on `dout` from that edge.
- `dclk` rises DCLK_HALF clocks after a unit appears and falls DCLK_HALF clocks later, at the same edge that moves to the next unit.
- `ok` or `err` rises one clock after the deciding input is sampled.

The bench models the target. On every system clock edge it compares the `dclk` and `dout` values from the two previous edges, so a rising edge and its captured data are recorded one clock late and never raced. All flag and code checks are made on the falling clock edge after polling for `ok` or `err`. Pulse width and edge counts are measured, not assumed.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PULSE     = 3'd1,
        ST_WAIT_STAT = 3'd2,
        ST_LOAD      = 3'd3,
        ST_FLUSH     = 3'd4,
        ST_INIT      = 3'd5,
        ST_OK        = 3'd6,
        ST_FAIL      = 3'd7
    } pcfg_state_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_STAT_TMO  = 3'd1,
        ERR_STAT_LOST = 3'd2,
        ERR_DONE_TMO  = 3'd3,
        ERR_INIT_TMO  = 3'd4
    } pcfg_err_e;

    // bits needed to hold the largest of three limits
    function automatic int span_bits(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pcfg_pacer.sv
module pcfg_pacer #(
    parameter int HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic dclk,
    output logic period_end
);
    localparam int CW = $clog2(2 * HALF);
    localparam logic [CW-1:0] LAST = CW'(2 * HALF - 1);
    localparam logic [CW-1:0] HI_AT = CW'(HALF);

    logic [CW-1:0] cnt_q;
    logic          dclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dclk_q <= 1'b0;
        end else if (!run || (cnt_q == LAST)) begin
            cnt_q  <= '0;
            dclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            dclk_q <= ((cnt_q + 1'b1) >= HI_AT);
        end
    end

    assign dclk       = dclk_q;
    assign period_end = (cnt_q == LAST);
endmodule

// File: rtl/pcfg_serializer.sv
module pcfg_serializer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] byte_in,
    input  logic          par,
    input  logic          advance,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          last_unit
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IW-1:0] TOP = IW'(DW - 1);

    logic [DW-1:0] byte_q;
    logic [IW-1:0] idx_q;
    logic          full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (clear) begin
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (load) begin
            byte_q <= byte_in;
            idx_q  <= '0;
            full_q <= 1'b1;
        end else if (advance && full_q) begin
            if (last_unit) begin
                full_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign last_unit = par || (idx_q == TOP);
    assign full      = full_q;

    always_comb begin
        dout = '0;
        if (full_q) begin
            if (par) begin
                dout = byte_q;
            end else begin
                dout[0] = byte_q[idx_q];
            end
        end
    end
endmodule

// File: rtl/pcfg_host.sv
module pcfg_host
    import pcfg_pkg::*;
#(
    parameter int DW         = 8,
    parameter int DCLK_HALF  = 1,
    parameter int PULSE_MIN  = 8,
    parameter int WAIT_TMO   = 1000,
    parameter int EXTRA_CLKS = 64,
    parameter int RETRY_MAX  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          par_mode,
    input  logic          use_init,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    output logic          src_restart,
    output logic          cfg_req_n,
    input  logic          cfg_status,
    input  logic          cfg_done,
    input  logic          cfg_init_done,
    output logic          dclk,
    output logic [DW-1:0] dout,
    output logic          busy,
    output logic          ok,
    output logic          err,
    output logic [2:0]    err_code
);
    localparam int TW = span_bits(PULSE_MIN, WAIT_TMO, EXTRA_CLKS);
    localparam int RW = $clog2(RETRY_MAX + 2);
    localparam logic [TW-1:0] PULSE_VAL = TW'(PULSE_MIN - 1);
    localparam logic [TW-1:0] WAIT_VAL  = TW'(WAIT_TMO - 1);
    localparam logic [TW-1:0] EXTRA_VAL = TW'(EXTRA_CLKS);
    localparam logic [RW-1:0] RETRY_LIM = RW'(RETRY_MAX);

    pcfg_state_e   state_q, state_nxt;
    pcfg_err_e     err_q, err_nxt;
    logic          par_q, init_q, last_q;
    logic [RW-1:0] retry_q;

    logic          wt_load, wt_zero, ct_load, ct_zero, ct_dec;
    logic [TW-1:0] wt_val;
    logic          ser_clear, ser_load, ser_adv, ser_full, ser_last;
    logic          retry_inc, retry_clr, can_retry;
    logic          run, period_end, take;

    assign can_retry = (retry_q < RETRY_LIM);
    assign take      = (state_q == ST_LOAD) && !ser_full && cfg_status && !start;

    pcfg_timer #(.W(TW)) u_wait_tmr (
        .clk(clk), .rst_n(rst_n), .load(wt_load), .val(wt_val),
        .dec(1'b1), .zero(wt_zero)
    );

    assign ct_dec = period_end && (state_q == ST_FLUSH);

    pcfg_timer #(.W(TW)) u_clk_tmr (
        .clk(clk), .rst_n(rst_n), .load(ct_load), .val(EXTRA_VAL),
        .dec(ct_dec), .zero(ct_zero)
    );

    pcfg_pacer #(.HALF(DCLK_HALF)) u_pacer (
        .clk(clk), .rst_n(rst_n), .run(run), .dclk(dclk), .period_end(period_end)
    );

    pcfg_serializer #(.DW(DW)) u_ser (
        .clk(clk), .rst_n(rst_n), .clear(ser_clear), .load(ser_load),
        .byte_in(s_data), .par(par_q), .advance(ser_adv),
        .dout(dout), .full(ser_full), .last_unit(ser_last)
    );

    // state register and values latched with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            par_q   <= 1'b0;
            init_q  <= 1'b0;
            last_q  <= 1'b0;
            retry_q <= '0;
        end else begin
            state_q <= state_nxt;
            err_q   <= err_nxt;
            if (start) begin
                par_q  <= par_mode;
                init_q <= use_init;
            end
            if (retry_clr) begin
                retry_q <= '0;
            end else if (retry_inc) begin
                retry_q <= retry_q + 1'b1;
            end
            if (ser_load) begin
                last_q <= s_last;
            end
        end
    end

    // next state and datapath controls
    always_comb begin
        state_nxt = state_q;
        err_nxt   = err_q;
        wt_load   = 1'b0;
        wt_val    = PULSE_VAL;
        ct_load   = 1'b0;
        ser_clear = 1'b0;
        ser_load  = 1'b0;
        ser_adv   = 1'b0;
        retry_inc = 1'b0;
        retry_clr = 1'b0;
        if (start) begin
            state_nxt = ST_PULSE;
            err_nxt   = ERR_NONE;
            wt_load   = 1'b1;
            ser_clear = 1'b1;
            retry_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_OK, ST_FAIL: begin
                end
                ST_PULSE: begin
                    if (wt_zero) begin
                        state_nxt = ST_WAIT_STAT;
                        wt_load   = 1'b1;
                        wt_val    = WAIT_VAL;
                    end
                end
                ST_WAIT_STAT: begin
                    if (cfg_status) begin
                        state_nxt = ST_LOAD;
                    end else if (wt_zero) begin
                        state_nxt = ST_FAIL;
                        err_nxt   = ERR_STAT_TMO;
                    end
                end
                ST_LOAD: begin
                    if (!cfg_status) begin
                        ser_clear = 1'b1;
                        if (can_retry) begin
                            state_nxt = ST_PULSE;
                            retry_inc = 1'b1;
                            wt_load   = 1'b1;
                        end else begin
                            state_nxt = ST_FAIL;
                            err_nxt   = ERR_STAT_LOST;
                        end
                    end else if (!ser_full) begin
                        ser_load = s_valid;
                    end else if (period_end) begin
                        ser_adv = 1'b1;
                        if (ser_last && last_q) begin
                            state_nxt = ST_FLUSH;
                            ct_load   = 1'b1;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (!cfg_status) begin
                        if (can_retry) begin
                            state_nxt = ST_PULSE;
                            retry_inc = 1'b1;
                            wt_load   = 1'b1;
                        end else begin
                            state_nxt = ST_FAIL;
                            err_nxt   = ERR_STAT_LOST;
                        end
                    end else if (cfg_done) begin
                        if (init_q) begin
                            state_nxt = ST_INIT;
                            wt_load   = 1'b1;
                            wt_val    = WAIT_VAL;
                        end else begin
                            state_nxt = ST_OK;
                        end
                    end else if (ct_zero) begin
                        state_nxt = ST_FAIL;
                        err_nxt   = ERR_DONE_TMO;
                    end
                end
                ST_INIT: begin
                    if (cfg_init_done) begin
                        state_nxt = ST_OK;
                    end else if (wt_zero) begin
                        state_nxt = ST_FAIL;
                        err_nxt   = ERR_INIT_TMO;
                    end
                end
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        cfg_req_n   = (state_q != ST_PULSE);
        src_restart = (state_q == ST_PULSE);
        busy        = (state_q != ST_IDLE) && (state_q != ST_OK) && (state_q != ST_FAIL);
        ok          = (state_q == ST_OK);
        err         = (state_q == ST_FAIL);
        err_code    = err_q;
        s_ready     = take;
        run         = (state_nxt == state_q) &&
                      (((state_q == ST_LOAD) && ser_full) ||
                       (state_q == ST_FLUSH) || (state_q == ST_INIT));
    end

endmodule

// File: rtl/pcfg_host_chk.sv
module pcfg_host_chk #(
    parameter int DW        = 8,
    parameter int PULSE_MIN = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_req_n,
    input logic          cfg_status,
    input logic          cfg_done,
    input logic          cfg_init_done,
    input logic          dclk,
    input logic [DW-1:0] dout,
    input logic          s_valid,
    input logic          s_ready,
    input logic          busy,
    input logic          ok,
    input logic          err,
    input logic [2:0]    err_code,
    input logic          par_q,
    input logic          init_q
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!cfg_req_n) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    p_req_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req_n) |-> (low_cnt == PULSE_MIN));

    p_accept_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> (cfg_status && cfg_req_n));

    p_dout_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk) |-> $stable(dout));

    p_serial_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !par_q) |-> (dout[DW-1:1] == '0));

    p_ok_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ok) && !init_q) |-> $past(cfg_done));

    p_ok_needs_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ok) && init_q) |-> $past(cfg_init_done));

    p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dclk && (dout == '0)));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));

    p_ok_clean_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (err_code == 3'd0));
endmodule

bind pcfg_host pcfg_host_chk #(.DW(DW), .PULSE_MIN(PULSE_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_req_n(cfg_req_n), .cfg_status(cfg_status),
    .cfg_done(cfg_done), .cfg_init_done(cfg_init_done), .dclk(dclk), .dout(dout),
    .s_valid(s_valid), .s_ready(s_ready), .busy(busy), .ok(ok), .err(err),
    .err_code(err_code), .par_q(par_q), .init_q(init_q)
);

// File: tb/pcfg_host_tb.sv
`timescale 1ns/1ps
module pcfg_host_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int HALF       = 2;
    localparam int PULSE_MIN  = 4;
    localparam int WAIT_TMO   = 40;
    localparam int EXTRA      = 6;
    localparam int RETRY_MAX  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, par_mode = 1'b0, use_init = 1'b0;
    logic [DW-1:0] s_data;
    logic s_valid, s_last, s_ready, src_restart, cfg_req_n;
    logic t_status = 1'b0, t_done = 1'b0, t_init = 1'b0;
    logic dclk, busy, ok, err;
    logic [DW-1:0] dout;
    logic [2:0] err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcfg_host #(.DW(DW), .DCLK_HALF(HALF), .PULSE_MIN(PULSE_MIN), .WAIT_TMO(WAIT_TMO),
                .EXTRA_CLKS(EXTRA), .RETRY_MAX(RETRY_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .par_mode(par_mode), .use_init(use_init),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .src_restart(src_restart), .cfg_req_n(cfg_req_n), .cfg_status(t_status),
        .cfg_done(t_done), .cfg_init_done(t_init), .dclk(dclk), .dout(dout),
        .busy(busy), .ok(ok), .err(err), .err_code(err_code)
    );

    int n_checks = 0, n_fail = 0;

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'(seed * 29 + i * 53 + (i >> 1));
    endfunction

    // byte source
    int src_n = 0, src_seed = 0, idx = 0;
    assign s_valid = (idx < src_n);
    assign s_data  = byte_of(src_seed, idx);
    assign s_last  = (idx == src_n - 1);
    always @(posedge clk) begin
        if (src_restart) idx <= 0;
        else if (s_valid && s_ready) idx <= idx + 1;
    end

    // target model and observers
    logic tgt_clear = 1'b0, tgt_par = 1'b0;
    int tgt_units = 0, stat_dly = 3, drop_cfg = 0, drop_at = 0;
    logic stat_never = 1'b0, done_never = 1'b0, init_never = 1'b0;
    logic dclk_prev = 1'b0, req_prev = 1'b1, dead = 1'b0;
    logic [DW-1:0] dout_prev = '0;
    int stat_cnt = 0, drops_used = 0, rises = 0, falls = 0, low_run = 0, low_w = 0;
    int r3_bad = 0, r4_bad = 0, xtra_bad = 0, bad_acc = 0;
    logic [7:0] rx_mem [16];

    always @(posedge clk) begin
        dclk_prev <= dclk;
        dout_prev <= dout;
        req_prev  <= cfg_req_n;
        if (tgt_clear) begin
            drops_used <= 0; rises <= 0; falls <= 0; low_run <= 0; low_w <= 0;
            r3_bad <= 0; r4_bad <= 0; xtra_bad <= 0; bad_acc <= 0;
        end else begin
            if (req_prev && !cfg_req_n) falls <= falls + 1;
            if (!cfg_req_n) low_run <= low_run + 1;
            else if (low_run != 0) begin low_w <= low_run; low_run <= 0; end
            if (s_valid && s_ready && !t_status) bad_acc <= bad_acc + 1;
            if (dclk && !dclk_prev) begin
                if (dout != dout_prev) r3_bad <= r3_bad + 1;
                if (rises < tgt_units) begin
                    if (tgt_par) rx_mem[rises] <= dout;
                    else begin
                        rx_mem[rises / 8][rises % 8] <= dout[0];
                        if (dout[DW-1:1] != '0) r4_bad <= r4_bad + 1;
                    end
                end else if (dout != '0) xtra_bad <= xtra_bad + 1;
                rises <= rises + 1;
            end
            if (!cfg_req_n) begin
                t_status <= 1'b0; t_done <= 1'b0; t_init <= 1'b0;
                stat_cnt <= 0; dead <= 1'b0; rises <= 0;
            end else begin
                if (!dead) begin
                    if (stat_cnt < stat_dly) stat_cnt <= stat_cnt + 1;
                    else if (!stat_never) t_status <= 1'b1;
                end
                if (t_status && !dead && drops_used < drop_cfg && rises >= drop_at) begin
                    dead <= 1'b1; t_status <= 1'b0; drops_used <= drops_used + 1;
                end else if (t_status && !dead && rises >= tgt_units && !done_never) begin
                    t_done <= 1'b1;
                end
                if (t_done && !init_never) t_init <= 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_load(input logic par, input logic uinit, input int n,
                            input int seed, input int restart_at);
        tgt_par = par; tgt_units = par ? n : 8 * n;
        src_n = n; src_seed = seed; par_mode = par; use_init = uinit;
        @(negedge clk) tgt_clear = 1'b1;
        @(negedge clk) begin tgt_clear = 1'b0; start = 1'b1; end
        @(negedge clk) start = 1'b0;
        for (int c = 0; c < 5000 && !ok && !err; c++) begin
            @(negedge clk);
            if (restart_at > 0 && c == restart_at) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_data(input string tag, input int n, input int seed);
        int bad = 0;
        for (int i = 0; i < n; i++) if (rx_mem[i] != byte_of(seed, i)) bad++;
        chk(tag, bad, 0);
    endtask

    typedef struct packed {
        logic       par;
        logic       uinit;
        logic       inever;
        logic [7:0] n;
        logic [7:0] seed;
        logic [2:0] code;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 1'b0, 8'd3,  8'h11, 3'd0},
        '{1'b1, 1'b0, 1'b0, 8'd5,  8'h2A, 3'd0},
        '{1'b0, 1'b1, 1'b0, 8'd2,  8'h5C, 3'd0},
        '{1'b1, 1'b1, 1'b0, 8'd12, 8'h03, 3'd0},
        '{1'b1, 1'b1, 1'b1, 8'd4,  8'h77, 3'd4},
        '{1'b0, 1'b0, 1'b1, 8'd2,  8'hC4, 3'd0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 req_n after reset", cfg_req_n, 1);
        chk("R9 dclk after reset", dclk, 0);
        chk("R9 dout after reset", dout, 0);
        chk("R9 busy/ok/err after reset", {busy, ok, err}, 0);
        chk("R9 s_ready after reset", s_ready, 0);
        chk("R9 err_code after reset", err_code, 0);

        for (int v = 0; v < 6; v++) begin
            init_never = VEC[v].inever;
            run_load(VEC[v].par, VEC[v].uinit, int'(VEC[v].n), int'(VEC[v].seed), 0);
            chk("R6 vector err_code", err_code, int'(VEC[v].code));
            chk("R5 vector ok flag", ok, (VEC[v].code == 3'd0) ? 1 : 0);
            chk_data("R4 vector data", int'(VEC[v].n), int'(VEC[v].seed));
            chk("R3 dout changed at dclk rise", r3_bad, 0);
            chk("R4 serial upper bits", r4_bad, 0);
            chk("R8 parked dout nonzero", xtra_bad, 0);
            chk("R1 request pulse width", low_w, PULSE_MIN);
            chk("R2 byte taken before status", bad_acc, 0);
        end
        init_never = 1'b0;

        // R9 result holds until next start
        repeat (20) @(negedge clk);
        chk("R9 ok held", ok, 1);
        chk("R9 not busy after ok", busy, 0);

        // R2 status never rises
        stat_never = 1'b1;
        run_load(1'b0, 1'b0, 2, 8'h31, 0);
        chk("R2 status timeout code", err_code, 1);
        chk("R2 no dclk rise", rises, 0);
        chk("R2 single pulse", falls, 1);
        chk("R8 dclk low after fail", dclk, 0);
        stat_never = 1'b0;

        // R7 one loss, recovered by a retry
        drop_cfg = 1; drop_at = 12;
        run_load(1'b0, 1'b0, 4, 8'h4D, 0);
        chk("R7 ok after retry", ok, 1);
        chk("R7 two pulses", falls, 2);
        chk_data("R7 data after retry", 4, 8'h4D);

        // R7 losses beyond the limit
        drop_cfg = 10; drop_at = 3;
        run_load(1'b1, 1'b0, 6, 8'h90, 0);
        chk("R7 status lost code", err_code, 2);
        chk("R7 pulse count", falls, RETRY_MAX + 1);
        drop_cfg = 0;

        // R5 done never rises
        done_never = 1'b1;
        run_load(1'b1, 1'b0, 3, 8'h5A, 0);
        chk("R5 done timeout code", err_code, 3);
        chk("R5 extra dclk edges", rises - 3, EXTRA);
        chk("R8 parked dout during extra clocks", xtra_bad, 0);
        done_never = 1'b0;

        // R1 restart while loading
        run_load(1'b0, 1'b0, 6, 8'hE1, 60);
        chk("R1 restart pulses", falls, 2);
        chk("R1 ok after restart", ok, 1);
        chk_data("R1 data after restart", 6, 8'hE1);
        chk("R1 restart pulse width", low_w, PULSE_MIN);

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule